// File: doc/BRIEF.md
# Flash Status Toggle-Bit Generator

This block sits on the read path of a flash device and decides what a read returns while the array is busy. When an embedded program or erase is running, or an erase is suspended, a read returns status bits instead of array data. The block produces three of those bits: `dq6` and `dq2`, which toggle, and `dq3`, which is a level. It also produces a flag that tells the output multiplexer whether status or array contents go on the bus. The operating mode, the set of sectors being erased or suspended, the sector decoded from the read address and a read strobe are all inputs. The array, the embedded timing and the command decoder live elsewhere.

The two toggle bits follow different rules. `dq6` advances on every status read while any program or erase activity is running, whatever sector is addressed. `dq2` advances only on reads that hit a sector in the erase set, and it keeps doing so while the erase is suspended. Host software reads twice and compares the bits. From the result it can tell active erase from suspend, and a sector being erased from one that is not.

Each toggle state is a flip-flop. It changes only on a read strobe and is cleared during any cycle in which the mode is read. The outputs are combinational from the current inputs and these two flip-flops. A read therefore returns the present state, and the strobe edge flips it for the next read.

Top module: `flash_status_toggle`

## Requirements
- R1: The mode input is encoded as 0 read, 1 program, 2 erase (sector collection window), 3 erase (committed), 4 erase-suspend-read and 5 erase-suspend-program; codes 6 and 7 behave as read. In read mode `status_sel` is 0 and `dq2`, `dq3` and `dq6` are all 0.
- R2: After reset, and after any cycle spent in read mode, the first status read returns `dq2` = 0 and `dq6` = 0.
- R3: In modes 1, 2, 3 and 5, every read strobe inverts `dq6` for the next read, whatever sector is addressed.
- R4: In modes 2 and 3, a read strobe whose sector is set in `erase_mask` (bit n stands for sector n) inverts `dq2` for the next read.
- R5: In modes 2 and 3, a read of a sector not in `erase_mask` still returns status (`status_sel` = 1), but `dq2` does not change.
- R6: In mode 4, a read of a sector in `erase_mask` returns status, inverts `dq2`, and leaves `dq6` unchanged.
- R7: In mode 4, a read of a sector not in `erase_mask`, or of a sector index outside the sector count, returns array data: `status_sel` = 0 and all status bits 0.
- R8: In mode 5, a read of a sector not in `erase_mask` returns `dq2` = 1; a read of a sector in `erase_mask` returns the toggle state of `dq2` and inverts it.
- R9: `dq3` is 1 in modes 3, 4 and 5 while status is returned, and 0 in mode 2.
- R10: In mode 1, `dq2` does not toggle.
- R11: A cycle without a read strobe changes neither toggle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Operating mode code (see R1) |
| erase_mask | input | NUM_SECTORS | Sectors being erased or suspended, one bit per sector |
| rd_sector | input | SEC_W | Sector decoded from the read address |
| rd_stb | input | 1 | One-cycle read strobe |
| status_sel | output | 1 | 1 = status bits are returned, 0 = array data |
| dq2 | output | 1 | Sector-selective toggle bit |
| dq3 | output | 1 | Erase-committed level |
| dq6 | output | 1 | Busy toggle bit |

## Verification
The bench mixes mode changes with sector reads. It targets reads just after the mode returns to read, where a design that failed to clear would resume from a stale phase. It reads unerased sectors during erase, where a design that toggled `dq2` on every read would hide which sector is busy. It also reads in erase-suspend-read mode, where letting `dq6` run would make suspend look like active erase. Out-of-range sector indexes and constant-one `dq2` in suspend-program mode are also exercised, as is the `dq3` difference between the collection window and committed erase, since a swapped level would make software believe a late sector command had been taken.

// File: rtl/fst_pkg.sv
package fst_pkg;

    typedef enum logic [2:0] {
        FM_READ      = 3'd0,
        FM_PROG      = 3'd1,
        FM_ERASE_ARM = 3'd2,
        FM_ERASE     = 3'd3,
        FM_SUSP_READ = 3'd4,
        FM_SUSP_PROG = 3'd5
    } fmode_e;

    // Per-mode behaviour of the status path
    typedef struct packed {
        logic idle;          // array read mode: clear toggles, no status
        logic bit6_run;      // dq6 advances on any strobe
        logic bit2_track;    // dq2 advances on strobes that hit the erase set
        logic status_any;    // status returned for every sector
        logic status_on_hit; // status returned only for erase-set sectors
        logic fixed_miss;    // dq2 reads 1 for sectors outside the erase set
        logic committed;     // dq3 level
    } mode_cls_t;

    typedef struct packed {
        logic status_sel;
        logic dq2;
        logic dq3;
        logic dq6;
    } status_out_t;

    function automatic mode_cls_t classify(input logic [2:0] code);
        mode_cls_t c;
        c = '0;
        case (code)
            FM_PROG: begin
                c.bit6_run   = 1'b1;
                c.status_any = 1'b1;
            end
            FM_ERASE_ARM: begin
                c.bit6_run   = 1'b1;
                c.bit2_track = 1'b1;
                c.status_any = 1'b1;
            end
            FM_ERASE: begin
                c.bit6_run   = 1'b1;
                c.bit2_track = 1'b1;
                c.status_any = 1'b1;
                c.committed  = 1'b1;
            end
            FM_SUSP_READ: begin
                c.bit2_track    = 1'b1;
                c.status_on_hit = 1'b1;
                c.committed     = 1'b1;
            end
            FM_SUSP_PROG: begin
                c.bit6_run   = 1'b1;
                c.bit2_track = 1'b1;
                c.status_any = 1'b1;
                c.fixed_miss = 1'b1;
                c.committed  = 1'b1;
            end
            default: c.idle = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fst_mode_decode.sv
module fst_mode_decode
    import fst_pkg::*;
(
    input  logic [2:0] mode,
    output mode_cls_t  cls
);

    always_comb begin
        cls = classify(mode);
    end

endmodule

// File: rtl/fst_sector_hit.sv
module fst_sector_hit #(
    parameter int NUM_SECTORS = 7,
    localparam int SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic [NUM_SECTORS-1:0] erase_mask,
    input  logic [SEC_W-1:0]       rd_sector,
    output logic                   hit
);

    logic [NUM_SECTORS-1:0] onehot;

    for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_dec
        assign onehot[s] = (rd_sector == SEC_W'(s));
    end

    assign hit = |(onehot & erase_mask);

endmodule

// File: rtl/fst_toggle_cell.sv
module fst_toggle_cell (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic advance,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            q <= 1'b0;
        end else if (advance) begin
            q <= ~q;
        end
    end

endmodule

// File: rtl/flash_status_toggle.sv
module flash_status_toggle
    import fst_pkg::*;
#(
    parameter int NUM_SECTORS = 7,
    localparam int SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [2:0]             mode,
    input  logic [NUM_SECTORS-1:0] erase_mask,
    input  logic [SEC_W-1:0]       rd_sector,
    input  logic                   rd_stb,
    output logic                   status_sel,
    output logic                   dq2,
    output logic                   dq3,
    output logic                   dq6
);

    mode_cls_t   cls;
    logic        hit;
    logic        t2_q;
    logic        t6_q;
    logic        adv2;
    logic        adv6;
    status_out_t so;

    fst_mode_decode i_dec (
        .mode (mode),
        .cls  (cls)
    );

    fst_sector_hit #(.NUM_SECTORS(NUM_SECTORS)) i_hit (
        .erase_mask (erase_mask),
        .rd_sector  (rd_sector),
        .hit        (hit)
    );

    assign adv6 = rd_stb & cls.bit6_run;
    assign adv2 = rd_stb & hit & cls.bit2_track;

    fst_toggle_cell i_t6 (
        .clk     (clk),
        .rst     (rst),
        .clear   (cls.idle),
        .advance (adv6),
        .q       (t6_q)
    );

    fst_toggle_cell i_t2 (
        .clk     (clk),
        .rst     (rst),
        .clear   (cls.idle),
        .advance (adv2),
        .q       (t2_q)
    );

    always_comb begin
        so = '0;
        if (cls.status_any || (cls.status_on_hit && hit)) begin
            so.status_sel = 1'b1;
            so.dq6        = t6_q;
            so.dq3        = cls.committed;
            so.dq2        = (cls.fixed_miss && !hit) ? 1'b1 : t2_q;
        end
    end

    assign status_sel = so.status_sel;
    assign dq2        = so.dq2;
    assign dq3        = so.dq3;
    assign dq6        = so.dq6;

endmodule

// File: rtl/flash_status_toggle_chk.sv
module flash_status_toggle_chk #(
    parameter int NUM_SECTORS = 7,
    localparam int SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic [2:0]             mode,
    input logic [NUM_SECTORS-1:0] erase_mask,
    input logic [SEC_W-1:0]       rd_sector,
    input logic                   rd_stb,
    input logic                   status_sel,
    input logic                   dq2,
    input logic                   dq3,
    input logic                   dq6,
    input logic                   t2_q,
    input logic                   t6_q
);

    logic [NUM_SECTORS-1:0] shifted;
    logic                   in_set;

    assign shifted = erase_mask >> rd_sector;
    assign in_set  = shifted[0];

    p_read_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd0 || mode >= 3'd6) |-> (!status_sel && !dq2 && !dq3 && !dq6));

    p_clear_after_read_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd0) |=> (!t2_q && !t6_q));

    p_prog_dq6_flip_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && mode == 3'd1) |=> (t6_q != $past(t6_q)));

    p_erase_miss_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && mode == 3'd3 && !in_set) |=> $stable(t2_q));

    p_susp_read_dq6_still_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd4) |=> $stable(t6_q));

    p_susp_read_miss_array_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd4 && !in_set) |-> !status_sel);

    p_susp_prog_miss_one_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd5 && !in_set) |-> dq2);

    p_dq3_level_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd2 || mode == 3'd3) |-> (dq3 == (mode == 3'd3)));

    p_idle_strobe_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!rd_stb && mode != 3'd0 && mode < 3'd6) |=> ($stable(t2_q) && $stable(t6_q)));

endmodule

bind flash_status_toggle flash_status_toggle_chk #(.NUM_SECTORS(NUM_SECTORS)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .erase_mask (erase_mask),
    .rd_sector  (rd_sector),
    .rd_stb     (rd_stb),
    .status_sel (status_sel),
    .dq2        (dq2),
    .dq3        (dq3),
    .dq6        (dq6),
    .t2_q       (t2_q),
    .t6_q       (t6_q)
);

// File: tb/test_flash_status_toggle.sv
module test_flash_status_toggle;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 7;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    mode = 3'd0;
    logic [NS-1:0] erase_mask = '0;
    logic [SW-1:0] rd_sector = '0;
    logic          rd_stb = 1'b0;
    logic          status_sel, dq2, dq3, dq6;

    int n_chk = 0;
    int n_bad = 0;
    bit m_t2 = 1'b0;
    bit m_t6 = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_status_toggle #(.NUM_SECTORS(NS)) i_flash_status_toggle (
        .clk(clk), .rst(rst), .mode(mode), .erase_mask(erase_mask),
        .rd_sector(rd_sector), .rd_stb(rd_stb), .status_sel(status_sel),
        .dq2(dq2), .dq3(dq3), .dq6(dq6)
    );

    function automatic bit f_idle(input logic [2:0] m);
        return (m == 3'd0) || (m >= 3'd6);
    endfunction

    function automatic bit f_hit(input logic [NS-1:0] mk, input logic [SW-1:0] sc);
        if (int'(sc) >= NS) return 1'b0;
        return mk[sc];
    endfunction

    function automatic bit f_status(input logic [2:0] m, input bit h);
        if (m == 3'd4) return h;
        return (m >= 3'd1) && (m <= 3'd5) && (m != 3'd4);
    endfunction

    function automatic string f_tag(input logic [2:0] m, input bit h);
        case (m)
            3'd1: return "R10";
            3'd2, 3'd3: return h ? "R4" : "R5";
            3'd4: return h ? "R6" : "R7";
            3'd5: return "R8";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: %s got %b expected %b", req, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare after settle, advance model at posedge
    task automatic cyc(input logic r, input logic [2:0] m, input logic [NS-1:0] mk,
                       input logic [SW-1:0] sc, input logic st, input string tag);
        bit h, s, e2, e3, e6;
        string t;
        @(negedge clk);
        rst = r; mode = m; erase_mask = mk; rd_sector = sc; rd_stb = st;
        #1;
        h  = f_hit(mk, sc);
        s  = f_status(m, h);
        e6 = s ? m_t6 : 1'b0;
        e3 = s && (m >= 3'd3) && (m <= 3'd5);
        e2 = !s ? 1'b0 : ((m == 3'd5 && !h) ? 1'b1 : m_t2);
        t  = (tag != "") ? tag : f_tag(m, h);
        if (!r) begin
            check(t, "status_sel", status_sel, s);
            check(t, "dq2", dq2, e2);
            check((tag != "") ? tag : "R9", "dq3", dq3, e3);
            check((tag != "") ? tag : ((m == 3'd4) ? "R6" : "R3"), "dq6", dq6, e6);
        end
        @(posedge clk);
        if (r || f_idle(m)) begin
            m_t2 = 1'b0;
            m_t6 = 1'b0;
        end else begin
            if (st && (m == 3'd1 || m == 3'd2 || m == 3'd3 || m == 3'd5)) m_t6 = ~m_t6;
            if (st && h && (m >= 3'd2) && (m <= 3'd5)) m_t2 = ~m_t2;
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        logic [2:0]    rm;
        logic [NS-1:0] rmk;
        void'($urandom(32'd4257));
        repeat (3) cyc(1'b1, 3'd1, '0, '0, 1'b0, "R2");
        // R2: reset state, first status read in program mode
        cyc(1'b0, 3'd1, '0, 3'd0, 1'b0, "R2");
        check("R2", "dq6 after reset", dq6, 1'b0);
        // R3: program mode dq6 toggles per strobe; R10 dq2 stays
        cyc(1'b0, 3'd1, '0, 3'd2, 1'b1, "R3");
        cyc(1'b0, 3'd1, '0, 3'd5, 1'b1, "R3");
        check("R3", "dq6 second read", dq6, 1'b1);
        cyc(1'b0, 3'd1, '0, 3'd6, 1'b1, "R10");
        // R11: no strobe, no change
        cyc(1'b0, 3'd1, '0, 3'd6, 1'b0, "R11");
        cyc(1'b0, 3'd1, '0, 3'd6, 1'b0, "R11");
        // R2: back to read clears, then erase
        cyc(1'b0, 3'd0, '0, 3'd0, 1'b1, "R1");
        cyc(1'b0, 3'd7, '0, 3'd0, 1'b1, "R1");
        cyc(1'b0, 3'd3, 7'b0000100, 3'd2, 1'b1, "R2");
        cyc(1'b0, 3'd3, 7'b0000100, 3'd2, 1'b1, "R4");
        check("R4", "dq2 second hit read", dq2, 1'b1);
        cyc(1'b0, 3'd3, 7'b0000100, 3'd5, 1'b1, "R5");
        cyc(1'b0, 3'd3, 7'b0000100, 3'd5, 1'b1, "R5");
        cyc(1'b0, 3'd2, 7'b0000100, 3'd2, 1'b1, "R9");
        // R6/R7: suspend read, incl. out-of-range sector 7
        cyc(1'b0, 3'd4, 7'b0000100, 3'd2, 1'b1, "R6");
        cyc(1'b0, 3'd4, 7'b0000100, 3'd2, 1'b1, "R6");
        cyc(1'b0, 3'd4, 7'b0000100, 3'd3, 1'b1, "R7");
        cyc(1'b0, 3'd4, 7'b1111111, 3'd7, 1'b1, "R7");
        // R8: suspend program
        cyc(1'b0, 3'd5, 7'b0000100, 3'd0, 1'b1, "R8");
        check("R8", "dq2 miss constant", dq2, 1'b1);
        cyc(1'b0, 3'd5, 7'b0000100, 3'd2, 1'b1, "R8");
        cyc(1'b0, 3'd5, 7'b0000100, 3'd2, 1'b1, "R8");
        // Random mix with sticky modes
        rm = 3'd3;
        rmk = 7'b0010010;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 9) == 0) rm = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 49) == 0) rmk = NS'($urandom);
            cyc(($urandom_range(0, 299) == 0), rm, rmk, SW'($urandom_range(0, 7)),
                ($urandom_range(0, 2) != 0), "");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule